// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside an integer ALU. It turns each ALU result into the six arithmetic status flags and keeps them in a flag register. The ALU supplies the two operands, the result, its carry or borrow out of the selected width, an operation class and an operand size. The block decides which flags to load from these inputs. Operations of the hold class leave every flag as it was, which covers data moves and jumps. Arithmetic classes load the full flag set. Four command classes set or clear the string direction bit and the interrupt-enable bit.

The operand size can be 8, 16 or 32 bits. It moves the bit boundary used by the zero, sign and overflow flags. Parity always looks at the low byte of the result. Flags are registered, so the new values appear one clock after the cycle in which the operation class is presented.

Top module: `sflag_gen`

## Requirements
- R1: While `rst_ni` is low, all eight flag outputs are 0, and they stay at 0 until the first update after reset is released.
- R2: For add (class 3'd1) and subtract (class 3'd2), `carry_o` takes the value of `carry_i`, which is the carry out after an add or the borrow after a subtract.
- R3: For the update classes 1, 2 and 3, `parity_o` is 1 when `result_i[7:0]` holds an even number of ones and 0 when it holds an odd number, at every operand size.
- R4: For add and subtract, `aux_carry_o` is the carry or borrow across the nibble boundary, equal to `op_a_i[4] ^ op_b_i[4] ^ result_i[4]`.
- R5: For update classes, `zero_o` is 1 exactly when the result bits inside the selected size are all 0, and `sign_o` is the top bit of that size. The size codes are 2'd0 = 8 bits, 2'd1 = 16 bits, and 2'd2 or 2'd3 = 32 bits. Result bits above the size have no effect.
- R6: `overflow_o` is set when a signed add gives a result whose sign differs from the two equal operand signs. It is also set when a signed subtract `a-b`, with operands of differing signs, gives a result whose sign differs from `a`. The sign bits are taken at the selected size.
- R7: For the logic class (3'd3), `carry_o`, `overflow_o` and `aux_carry_o` are loaded with 0.
- R8: For the hold class (3'd0), all eight flag outputs keep their previous values.
- R9: Class 3'd4 sets `dir_o` and class 3'd5 clears it. No other class changes `dir_o`. The six arithmetic flags are not changed by classes 4 to 7.
- R10: Class 3'd6 sets `int_en_o` and class 3'd7 clears it. No other class changes `int_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_cls_i | input | 3 | Operation class: 0 hold, 1 add, 2 sub, 3 logic, 4/5 set/clear direction, 6/7 set/clear interrupt enable |
| size_i | input | 2 | Operand size: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| op_a_i | input | 32 | First ALU operand |
| op_b_i | input | 32 | Second ALU operand |
| result_i | input | 32 | ALU result |
| carry_i | input | 1 | Carry or borrow out of the selected width |
| carry_o | output | 1 | Carry flag |
| parity_o | output | 1 | Even-parity flag of the low result byte |
| aux_carry_o | output | 1 | Nibble carry flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| overflow_o | output | 1 | Signed overflow flag |
| dir_o | output | 1 | Direction control bit |
| int_en_o | output | 1 | Interrupt-enable control bit |

## Verification
Adds and subtracts are run at each of the three sizes using operands chosen so that the carry, the nibble carry and the signed overflow each switch independently. These cases show whether each flag reads its bit at the right boundary. Some results have stray bits above the selected size, which shows whether the zero and sign flags are masked by size rather than taken over the full word. Logic operations with odd and even low bytes separate the parity flag from the forced-zero flags. Hold operations and control-bit commands given after a busy flag state show that each class changes only the flags it owns.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  typedef enum logic [2:0] {
    CLS_HOLD    = 3'd0,
    CLS_ADD     = 3'd1,
    CLS_SUB     = 3'd2,
    CLS_LOGIC   = 3'd3,
    CLS_DIR_SET = 3'd4,
    CLS_DIR_CLR = 3'd5,
    CLS_IE_SET  = 3'd6,
    CLS_IE_CLR  = 3'd7
  } op_cls_e;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_32X = 2'd3
  } op_size_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } arith_flags_t;
endpackage

// File: rtl/sflag_width_sel.sv
module sflag_width_sel
  import sflag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              zero_o,
  output logic              msb_r_o,
  output logic              msb_a_o,
  output logic              msb_b_o
);
  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int SEL_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [NUM_LANES-1:0] lane_zero, lane_en, lane_msb_r, lane_msb_a, lane_msb_b;
  logic [SEL_W-1:0]     top_lane;

  // highest byte lane covered by the operand size
  always_comb begin
    top_lane = SEL_W'(NUM_LANES - 1);
    if (size_i == SZ_8)                        top_lane = '0;
    else if (size_i == SZ_16 && NUM_LANES > 1) top_lane = SEL_W'(1);
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_zero[g]  = ~|res_i[g*LANE_W +: LANE_W];
    assign lane_en[g]    = (SEL_W'(g) <= top_lane);
    assign lane_msb_r[g] = res_i[g*LANE_W + LANE_W - 1];
    assign lane_msb_a[g] = a_i[g*LANE_W + LANE_W - 1];
    assign lane_msb_b[g] = b_i[g*LANE_W + LANE_W - 1];
  end

  assign zero_o  = &(lane_zero | ~lane_en);
  assign msb_r_o = lane_msb_r[top_lane];
  assign msb_a_o = lane_msb_a[top_lane];
  assign msb_b_o = lane_msb_b[top_lane];
endmodule

// File: rtl/sflag_arith_calc.sv
module sflag_arith_calc
  import sflag_pkg::*;
#(
  parameter int NIB_BIT = 4
) (
  input  logic [2:0]   cls_i,
  input  logic         cout_i,
  input  logic [7:0]   res_lo_i,
  input  logic         a_nib_i,
  input  logic         b_nib_i,
  input  logic         zero_i,
  input  logic         msb_r_i,
  input  logic         msb_a_i,
  input  logic         msb_b_i,
  output logic         upd_o,
  output arith_flags_t nxt_o
);
  logic is_add, is_sub, is_logic, arith;

  assign is_add   = (cls_i == CLS_ADD);
  assign is_sub   = (cls_i == CLS_SUB);
  assign is_logic = (cls_i == CLS_LOGIC);
  assign arith    = is_add | is_sub;
  assign upd_o    = arith | is_logic;

  always_comb begin
    nxt_o.pf = ~^res_lo_i;
    nxt_o.zf = zero_i;
    nxt_o.sf = msb_r_i;
    nxt_o.cf = arith & cout_i;
    nxt_o.af = arith & (a_nib_i ^ b_nib_i ^ res_lo_i[NIB_BIT]);
    if (is_add)      nxt_o.of = (msb_a_i == msb_b_i) & (msb_r_i != msb_a_i);
    else if (is_sub) nxt_o.of = (msb_a_i != msb_b_i) & (msb_r_i != msb_a_i);
    else             nxt_o.of = 1'b0;
  end
endmodule

// File: rtl/sflag_reg.sv
module sflag_reg
  import sflag_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   cls_i,
  input  logic         upd_i,
  input  arith_flags_t nxt_i,
  output arith_flags_t flags_o,
  output logic         df_o,
  output logic         ie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      df_o    <= 1'b0;
      ie_o    <= 1'b0;
    end else begin
      if (upd_i) flags_o <= nxt_i;
      case (cls_i)
        CLS_DIR_SET: df_o <= 1'b1;
        CLS_DIR_CLR: df_o <= 1'b0;
        CLS_IE_SET:  ie_o <= 1'b1;
        CLS_IE_CLR:  ie_o <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sflag_gen.sv
module sflag_gen
  import sflag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_cls_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  output logic              carry_o,
  output logic              parity_o,
  output logic              aux_carry_o,
  output logic              zero_o,
  output logic              sign_o,
  output logic              overflow_o,
  output logic              dir_o,
  output logic              int_en_o
);
  localparam int NIB_BIT = 4;

  logic         zero_w, msb_r, msb_a, msb_b, upd;
  arith_flags_t nxt, flags;

  sflag_width_sel #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_width (
    .size_i (size_i),
    .res_i  (result_i),
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .zero_o (zero_w),
    .msb_r_o(msb_r),
    .msb_a_o(msb_a),
    .msb_b_o(msb_b)
  );

  sflag_arith_calc #(.NIB_BIT(NIB_BIT)) u_calc (
    .cls_i   (op_cls_i),
    .cout_i  (carry_i),
    .res_lo_i(result_i[7:0]),
    .a_nib_i (op_a_i[NIB_BIT]),
    .b_nib_i (op_b_i[NIB_BIT]),
    .zero_i  (zero_w),
    .msb_r_i (msb_r),
    .msb_a_i (msb_a),
    .msb_b_i (msb_b),
    .upd_o   (upd),
    .nxt_o   (nxt)
  );

  sflag_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cls_i  (op_cls_i),
    .upd_i  (upd),
    .nxt_i  (nxt),
    .flags_o(flags),
    .df_o   (dir_o),
    .ie_o   (int_en_o)
  );

  assign carry_o     = flags.cf;
  assign parity_o    = flags.pf;
  assign aux_carry_o = flags.af;
  assign zero_o      = flags.zf;
  assign sign_o      = flags.sf;
  assign overflow_o  = flags.of;
endmodule

// File: rtl/sflag_gen_chk.sv
module sflag_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] op_cls_i,
  input logic [7:0] res_lo_i,
  input logic       carry_o,
  input logic       parity_o,
  input logic       aux_carry_o,
  input logic       zero_o,
  input logic       sign_o,
  input logic       overflow_o,
  input logic       dir_o,
  input logic       int_en_o
);
  logic [5:0] arith_q;
  assign arith_q = {carry_o, parity_o, aux_carry_o, zero_o, sign_o, overflow_o};

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (arith_q == '0) && !dir_o && !int_en_o);

  a_r3_even_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i inside {3'd1, 3'd2, 3'd3}) |=> parity_o == ~^$past(res_lo_i));

  a_r5_zero_not_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> !sign_o);

  a_r7_logic_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i == 3'd3) |=> !carry_o && !overflow_o && !aux_carry_o);

  a_r8_hold_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i == 3'd0) |=> $stable(arith_q) && $stable(dir_o) && $stable(int_en_o));

  a_r9_dir_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i == 3'd4) |=> dir_o);

  a_r9_dir_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i == 3'd5) |=> !dir_o);

  a_r9_cmd_keeps_arith: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i[2]) |=> $stable(arith_q));

  a_r9_dir_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i != 3'd4 && op_cls_i != 3'd5) |=> $stable(dir_o));

  a_r10_ie_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i == 3'd6) |=> int_en_o);

  a_r10_ie_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i == 3'd7) |=> !int_en_o);

  a_r10_ie_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i != 3'd6 && op_cls_i != 3'd7) |=> $stable(int_en_o));
endmodule

bind sflag_gen sflag_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_cls_i   (op_cls_i),
  .res_lo_i   (result_i[7:0]),
  .carry_o    (carry_o),
  .parity_o   (parity_o),
  .aux_carry_o(aux_carry_o),
  .zero_o     (zero_o),
  .sign_o     (sign_o),
  .overflow_o (overflow_o),
  .dir_o      (dir_o),
  .int_en_o   (int_en_o)
);

// File: tb/sflag_gen_tb.sv
module sflag_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_cls_i = 3'd0;
  logic [1:0]  size_i = 2'd0;
  logic [31:0] op_a_i = '0, op_b_i = '0, result_i = '0;
  logic        carry_i = 1'b0;
  logic        carry_o, parity_o, aux_carry_o, zero_o, sign_o, overflow_o, dir_o, int_en_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] exp_ar = '0;  // {cf,pf,af,zf,sf,of}
  logic       exp_df = 1'b0, exp_ie = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sflag_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_cls_i(op_cls_i), .size_i(size_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .result_i(result_i), .carry_i(carry_i),
    .carry_o(carry_o), .parity_o(parity_o), .aux_carry_o(aux_carry_o),
    .zero_o(zero_o), .sign_o(sign_o), .overflow_o(overflow_o),
    .dir_o(dir_o), .int_en_o(int_en_o)
  );

  function automatic int width_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [5:0] model(input logic [2:0] cls, input logic [1:0] sz,
                                       input logic [31:0] a, input logic [31:0] b,
                                       input logic [31:0] r, input logic c);
    int w = width_of(sz);
    logic [63:0] m = (64'd1 << w) - 64'd1;
    logic sa = a[w-1], sb = b[w-1], sr = r[w-1];
    logic cf, pf, af, zf, sf, ovf;
    pf = ~^r[7:0];
    zf = ((64'(r) & m) == 64'd0);
    sf = sr;
    cf = (cls != 3'd3) & c;
    af = (cls != 3'd3) & (a[4] ^ b[4] ^ r[4]);
    if (cls == 3'd1)      ovf = (sa == sb) && (sr != sa);
    else if (cls == 3'd2) ovf = (sa != sb) && (sr != sa);
    else                  ovf = 1'b0;
    return {cf, pf, af, zf, sf, ovf};
  endfunction

  task automatic check(input string tag);
    logic [7:0] got = {carry_o, parity_o, aux_carry_o, zero_o, sign_o, overflow_o, dir_o, int_en_o};
    logic [7:0] exp = {exp_ar, exp_df, exp_ie};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b ({cf,pf,af,zf,sf,of,df,ie})", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge load, return to hold.
  task automatic apply(input logic [2:0] cls, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] r, input logic c);
    op_cls_i = cls; size_i = sz; op_a_i = a; op_b_i = b; result_i = r; carry_i = c;
    if (cls inside {3'd1, 3'd2, 3'd3}) exp_ar = model(cls, sz, a, b, r, c);
    case (cls)
      3'd4: exp_df = 1'b1;
      3'd5: exp_df = 1'b0;
      3'd6: exp_ie = 1'b1;
      3'd7: exp_ie = 1'b0;
      default: ;
    endcase
    @(negedge clk_i);
    op_cls_i = 3'd0;
  endtask

  task automatic do_add(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] b, input string tag);
    int w = width_of(sz);
    logic [63:0] m = (64'd1 << w) - 64'd1;
    logic [63:0] s = (64'(a) & m) + (64'(b) & m);
    apply(3'd1, sz, a, b, 32'(s & m), s[w]);
    check(tag);
  endtask

  task automatic do_sub(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] b, input string tag);
    int w = width_of(sz);
    logic [63:0] m = (64'd1 << w) - 64'd1;
    logic [63:0] d = (64'(a) & m) - (64'(b) & m);
    apply(3'd2, sz, a, b, 32'(d & m), (64'(a) & m) < (64'(b) & m));
    check(tag);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release");
  endtask

  task automatic t_add();
    do_add(2'd0, 32'h0000_00FF, 32'h0000_0001, "R2 R5 add8 wrap to zero");
    do_add(2'd0, 32'h0000_007F, 32'h0000_0001, "R6 R4 add8 signed overflow");
    do_add(2'd1, 32'h0000_7FFF, 32'h0000_0001, "R6 add16 overflow");
    do_add(2'd1, 32'h0000_8000, 32'h0000_8000, "R2 R6 add16 carry and overflow");
    do_add(2'd2, 32'hFFFF_FFFF, 32'h0000_0001, "R2 R5 add32 carry zero");
    do_add(2'd3, 32'h4000_0000, 32'h4000_0000, "R5 R6 add32 size code 3");
    do_add(2'd0, 32'h0000_0008, 32'h0000_0008, "R4 nibble carry only");
  endtask

  task automatic t_sub();
    do_sub(2'd0, 32'h0000_0000, 32'h0000_0001, "R2 R4 sub8 borrow");
    do_sub(2'd0, 32'h0000_0080, 32'h0000_0001, "R6 sub8 signed overflow");
    do_sub(2'd1, 32'h0000_1234, 32'h0000_1234, "R5 sub16 zero");
    do_sub(2'd2, 32'h8000_0000, 32'h0000_0001, "R6 sub32 overflow");
    do_sub(2'd2, 32'h0000_0010, 32'h0000_0001, "R4 sub32 nibble borrow");
  endtask

  task automatic t_logic();
    apply(3'd3, 2'd0, 32'h0000_0010, 32'h0000_0000, 32'hFFFF_FF00, 1'b1);
    check("R7 R5 logic8 upper bits ignored");
    apply(3'd3, 2'd1, 32'h0000_0000, 32'h0000_0000, 32'h0000_8007, 1'b1);
    check("R3 R7 logic16 odd parity negative");
    apply(3'd3, 2'd2, 32'h0000_0000, 32'h0000_0000, 32'h8000_0003, 1'b0);
    check("R3 R5 logic32 even parity sign");
  endtask

  task automatic t_hold();
    do_add(2'd0, 32'h0000_00FF, 32'h0000_0081, "R8 setup");
    apply(3'd0, 2'd2, 32'h0, 32'h0, 32'h0, 1'b0);
    check("R8 hold after busy state");
    repeat (3) @(negedge clk_i);
    check("R8 hold over idle cycles");
  endtask

  task automatic t_dir();
    apply(3'd4, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0);
    check("R9 direction set, arith flags kept");
    do_add(2'd0, 32'h1, 32'h1, "R9 direction kept by add");
    apply(3'd5, 2'd0, 32'hFF, 32'h1, 32'h0, 1'b1);
    check("R9 direction cleared");
  endtask

  task automatic t_ie();
    apply(3'd6, 2'd0, 32'h0, 32'h0, 32'h0, 1'b1);
    check("R10 interrupt enable set");
    apply(3'd3, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0);
    check("R10 interrupt enable kept by logic");
    apply(3'd4, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0);
    apply(3'd7, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0);
    check("R10 interrupt enable cleared, direction kept");
  endtask

  task automatic t_reset_mid();
    do_sub(2'd0, 32'h0, 32'h1, "R1 setup");
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    exp_ar = '0; exp_df = 1'b0; exp_ie = 1'b0;
    #1;
    check("R1 asynchronous clear");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 clear kept after release");
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1-related timeout: got hung expected finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_hold();
    t_dir();
    t_ie();
    t_reset_mid();
    finish_run();
  end
endmodule